// File: doc/BRIEF.md
# Constant-Fraction Timing Extractor

This block turns one burst of digitized waveform samples into a sub-sample arrival time. Each sample enters with a sample-index tag. The block stores the burst and tracks the largest sample while the burst arrives. When the burst closes, the block sets a threshold at a programmable fraction of the pulse height above a supplied baseline. It then walks backwards from the peak to find the two samples on the leading edge that straddle that threshold. A linear interpolation between those two samples, done by a restoring divider, gives the fractional part of the time.

The threshold follows the height of each pulse, so pulses of different size that have the same shape give the same time. A fixed threshold would make the time depend on amplitude. The result is a fixed-point word: the tag of the lower bracketing sample forms the integer part, and the interpolated fraction fills the low bits. If no usable crossing exists before the peak, a miss flag is raised instead of a time.

Top module: `cfd_timer`

## Requirements
- R1: The peak of an event is the largest sample value in it. When several samples share the largest value, the earliest one is the peak.
- R2: The threshold is `cfg_base + floor((peak - cfg_base) * cfg_frac / 2^KF)`. Here `cfg_frac` is an unsigned fraction with KF = 8 fractional bits, so the value n means n/256.
- R3: The lower bracketing sample is the last sample before the peak whose value is at or below the threshold. The upper bracketing sample is the one that follows it. A sample equal to the threshold therefore becomes the lower sample.
- R4: On a hit, `t_time[IW+FW-1:FW]` holds the index tag of the lower sample. `t_time[FW-1:0]` holds `floor((thr - lower) * 2^FW / (upper - lower))`, with FW = 8.
- R5: `t_miss` is raised with `t_valid` and `t_time` is all zero in two cases: the peak does not exceed `cfg_base`, or no sample before the peak is at or below the threshold. A peak at the first sample position is one such case.
- R6: `t_valid` is high for exactly one cycle per event. `t_miss` is never high without `t_valid`.
- R7: `s_ready` is low from the cycle after the closing sample is accepted up to the result cycle. It is high again in the cycle where `t_valid` is high. Samples offered while `s_ready` is low are ignored and do not change the result.
- R8: Let the closing sample be accepted at clock edge E. On a hit, `t_valid` rises at edge E + 2 + m + FW, where m is the peak position minus the lower-sample position. On a miss it rises at E + 2 + P, where P is the peak position within the event. When the peak does not exceed the baseline, it rises at E + 2.
- R9: A sample offered with `s_first` high starts a new event. It discards any samples of an unfinished event.
- R10: An event closes after its DEPTH-th sample (default 32) even if `s_last` is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample offered |
| s_first | input | 1 | Offered sample opens a new event |
| s_last | input | 1 | Offered sample closes the event |
| s_sample | input | DW | Unsigned sample value |
| s_index | input | IW | Index tag of the sample |
| s_ready | output | 1 | Block accepts samples |
| cfg_frac | input | KF | Constant fraction, KF fractional bits |
| cfg_base | input | DW | Baseline level |
| t_valid | output | 1 | Result pulse |
| t_time | output | IW+FW | Index tag and interpolated fraction |
| t_miss | output | 1 | No crossing found |

## Verification
Every result has a fixed latency, counted from the clock edge that accepts the closing sample. A hit is due 2 + m + FW edges later, where m is how far the lower sample sits behind the peak. A miss is due 2 + P edges later, or 2 edges later for a pulse no higher than the baseline. The driver records the edge number of that acceptance and queues it with the expected word. The monitor samples on falling edges, pops the queue entry when a result appears, and compares the elapsed edge count with the latency worked out from the sample values.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

   // Event processing phases
   typedef enum logic [1:0] {
      ST_FILL = 2'd0,   // collecting samples, peak tracked on the fly
      ST_THR  = 2'd1,   // threshold registered from the peak
      ST_SCAN = 2'd2,   // backward walk from the peak, one sample per cycle
      ST_DIV  = 2'd3    // fraction being divided out
   } cfd_state_e;

endpackage

// File: rtl/cfd_capture.sv
module cfd_capture #(
   parameter int DW    = 12,
   parameter int IW    = 16,
   parameter int DEPTH = 32,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_first,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] wr_idx,
   output logic [AW-1:0] wr_addr,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] rd_next_data,
   output logic [IW-1:0] rd_idx,
   output logic [DW-1:0] peak_val,
   output logic [AW-1:0] peak_addr
);

   logic [AW-1:0] fill_q;
   logic [DW-1:0] cell_d [DEPTH];
   logic [IW-1:0] cell_i [DEPTH];

   assign wr_addr = wr_first ? '0 : fill_q;

   // one storage cell per sample slot
   for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      logic [DW-1:0] d_q;
      logic [IW-1:0] i_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == AW'(e))) begin
            d_q <= wr_data;
            i_q <= wr_idx;
         end
      end
      assign cell_d[e] = d_q;
      assign cell_i[e] = i_q;
   end

   assign rd_data      = cell_d[rd_addr];
   assign rd_idx       = cell_i[rd_addr];
   assign rd_next_data = cell_d[rd_addr + AW'(1)];

   // strict compare keeps the earliest of equal maxima
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q    <= '0;
         peak_val  <= '0;
         peak_addr <= '0;
      end else if (wr_en) begin
         fill_q <= wr_addr + AW'(1);
         if (wr_first || (wr_data > peak_val)) begin
            peak_val  <= wr_data;
            peak_addr <= wr_addr;
         end
      end
   end

endmodule

// File: rtl/cfd_frac_div.sv
module cfd_frac_div #(
   parameter int NW = 12,
   parameter int FW = 8,
   parameter int CW = $clog2(FW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  logic [NW-1:0] den,
   output logic          done,
   output logic [FW-1:0] quo
);

   logic [NW-1:0] rem_q;
   logic [NW-1:0] den_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic [NW:0]   dbl;
   logic          take;

   // num < den holds on entry, so the shifted remainder fits NW+1 bits
   assign dbl  = {rem_q, 1'b0};
   assign take = dbl >= {1'b0, den_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done   <= 1'b0;
         quo    <= '0;
      end else if (start) begin
         rem_q  <= num;
         den_q  <= den;
         cnt_q  <= CW'(FW);
         busy_q <= 1'b1;
         done   <= 1'b0;
         quo    <= '0;
      end else if (busy_q) begin
         rem_q <= take ? NW'(dbl - {1'b0, den_q}) : dbl[NW-1:0];
         quo   <= {quo[FW-2:0], take};
         cnt_q <= cnt_q - CW'(1);
         if (cnt_q == CW'(1)) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
         end
      end else begin
         done <= 1'b0;
      end
   end

endmodule

// File: rtl/cfd_timer.sv
module cfd_timer
   import cfd_pkg::*;
#(
   parameter int DW    = 12,
   parameter int IW    = 16,
   parameter int KF    = 8,
   parameter int FW    = 8,
   parameter int DEPTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_valid,
   input  logic             s_first,
   input  logic             s_last,
   input  logic [DW-1:0]    s_sample,
   input  logic [IW-1:0]    s_index,
   output logic             s_ready,
   input  logic [KF-1:0]    cfg_frac,
   input  logic [DW-1:0]    cfg_base,
   output logic             t_valid,
   output logic [IW+FW-1:0] t_time,
   output logic             t_miss
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = DW + KF;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cfd_timer: DEPTH must be a power of two of at least 4");
   end
   if (DW < 2 || KF < 1 || FW < 2) begin : g_bad_width
      $error("cfd_timer: DW and FW need at least 2 bits, KF at least 1");
   end

   cfd_state_e    state_q;
   logic          open_q;
   logic [AW-1:0] scan_q;
   logic [DW-1:0] thr_q;
   logic          flat_q;
   logic [IW-1:0] lo_idx_q;

   logic          accept, end_evt, hit, div_start, div_done;
   logic [AW-1:0] wr_addr, rd_addr, peak_addr;
   logic [DW-1:0] rd_data, rd_next_data, peak_val;
   logic [IW-1:0] rd_idx;
   logic [DW-1:0] amp_c, thr_c;
   logic [PW-1:0] prod_c;
   logic [FW-1:0] div_quo;

   assign s_ready = (state_q == ST_FILL);
   assign accept  = s_valid && s_ready;
   assign end_evt = accept && (s_last || (wr_addr == AW'(DEPTH - 1)));

   cfd_capture #(.DW(DW), .IW(IW), .DEPTH(DEPTH), .AW(AW)) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (accept),
      .wr_first     (s_first || !open_q),
      .wr_data      (s_sample),
      .wr_idx       (s_index),
      .wr_addr      (wr_addr),
      .rd_addr      (rd_addr),
      .rd_data      (rd_data),
      .rd_next_data (rd_next_data),
      .rd_idx       (rd_idx),
      .peak_val     (peak_val),
      .peak_addr    (peak_addr)
   );

   // threshold at the programmed fraction of the height above baseline
   assign amp_c  = (peak_val > cfg_base) ? (peak_val - cfg_base) : '0;
   assign prod_c = PW'(amp_c) * PW'(cfg_frac);
   assign thr_c  = cfg_base + DW'(prod_c >> KF);

   // backward walk: candidate lower sample sits one slot below scan_q
   assign rd_addr   = scan_q - AW'(1);
   assign hit       = rd_data <= thr_q;
   assign div_start = (state_q == ST_SCAN) && !flat_q && (scan_q != '0) && hit;

   cfd_frac_div #(.NW(DW), .FW(FW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .num   (thr_q - rd_data),
      .den   (rd_next_data - rd_data),
      .done  (div_done),
      .quo   (div_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_FILL;
         open_q   <= 1'b0;
         scan_q   <= '0;
         thr_q    <= '0;
         flat_q   <= 1'b0;
         lo_idx_q <= '0;
         t_valid  <= 1'b0;
         t_miss   <= 1'b0;
         t_time   <= '0;
      end else begin
         t_valid <= 1'b0;
         t_miss  <= 1'b0;
         if (accept) open_q <= !end_evt;
         unique case (state_q)
            ST_FILL: if (end_evt) state_q <= ST_THR;
            ST_THR: begin
               thr_q   <= thr_c;
               flat_q  <= (peak_val <= cfg_base);
               scan_q  <= peak_addr;
               state_q <= ST_SCAN;
            end
            ST_SCAN: begin
               if (flat_q || (scan_q == '0)) begin
                  t_valid <= 1'b1;
                  t_miss  <= 1'b1;
                  t_time  <= '0;
                  state_q <= ST_FILL;
               end else if (hit) begin
                  lo_idx_q <= rd_idx;
                  state_q  <= ST_DIV;
               end else begin
                  scan_q <= scan_q - AW'(1);
               end
            end
            ST_DIV: if (div_done) begin
               t_valid <= 1'b1;
               t_time  <= {lo_idx_q, div_quo};
               state_q <= ST_FILL;
            end
            default: state_q <= ST_FILL;
         endcase
      end
   end

endmodule

// File: rtl/cfd_timer_chk.sv
module cfd_timer_chk #(
   parameter int TW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          s_valid,
   input logic          s_last,
   input logic          s_ready,
   input logic          t_valid,
   input logic          t_miss,
   input logic [TW-1:0] t_time
);

   AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid |=> !t_valid); // R6

   AST_MISS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      t_miss |-> t_valid); // R6

   AST_MISS_TIME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      t_miss |-> (t_time == '0)); // R5

   AST_BUSY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready && s_last) |=> !s_ready); // R7

   AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid |-> s_ready); // R7

endmodule

bind cfd_timer cfd_timer_chk #(.TW(IW + FW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_valid (s_valid),
   .s_last  (s_last),
   .s_ready (s_ready),
   .t_valid (t_valid),
   .t_miss  (t_miss),
   .t_time  (t_time)
);

// File: tb/cfd_timer_tb_top.sv
`timescale 1ns/1ps
module cfd_timer_tb_top;

   localparam int DW = 12, IW = 16, KF = 8, FW = 8, DEPTH = 32;
   localparam int TW = IW + FW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
   logic [DW-1:0] s_sample = '0;
   logic [IW-1:0] s_index = '0;
   logic          s_ready;
   logic [KF-1:0] cfg_frac = '0;
   logic [DW-1:0] cfg_base = '0;
   logic          t_valid, t_miss;
   logic [TW-1:0] t_time;

   cfd_timer #(.DW(DW), .IW(IW), .KF(KF), .FW(FW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_first(s_first),
      .s_last(s_last), .s_sample(s_sample), .s_index(s_index),
      .s_ready(s_ready), .cfg_frac(cfg_frac), .cfg_base(cfg_base),
      .t_valid(t_valid), .t_time(t_time), .t_miss(t_miss)
   );

   always #4 clk = ~clk;   // 125 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, fails = 0;

   typedef struct {
      logic [TW-1:0] t;
      logic          miss;
      int            lat;
      int            acc_at;
      string         name;
   } exp_t;

   exp_t exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference model written from the requirements
   function automatic exp_t model(input int smp[$], input int idx0,
                                  input int k, input int base);
      exp_t e;
      int n, p, amp, thr, lo;
      n = smp.size();
      if (n > DEPTH) n = DEPTH;
      p = 0;
      for (int i = 1; i < n; i++) if (smp[i] > smp[p]) p = i;      // R1
      amp = (smp[p] > base) ? smp[p] - base : 0;
      thr = base + ((amp * k) >> KF);                             // R2
      e.miss = 1'b1;
      e.t    = '0;
      if (amp == 0) e.lat = 2;
      else begin
         lo = -1;
         for (int i = p - 1; i >= 0; i--)
            if (smp[i] <= thr) begin lo = i; break; end           // R3
         if (lo < 0) e.lat = 2 + p;
         else begin
            e.miss = 1'b0;
            e.t    = {IW'(idx0 + lo),
                      FW'(((thr - smp[lo]) << FW) / (smp[lo+1] - smp[lo]))};
            e.lat  = 2 + (p - lo) + FW;                           // R8
         end
      end
      return e;
   endfunction

   task automatic send_event(input int smp[$], input int idx0, input int k,
                             input int base, input bit use_last, input string name);
      exp_t e;
      int n;
      e = model(smp, idx0, k, base);
      e.name = name;
      n = (smp.size() > DEPTH) ? DEPTH : smp.size();
      @(posedge clk); #1;
      while (!s_ready) begin @(posedge clk); #1; end
      cfg_frac = KF'(k);
      cfg_base = DW'(base);
      for (int i = 0; i < n; i++) begin
         s_valid  = 1'b1;
         s_first  = (i == 0);
         s_last   = use_last && (i == n - 1);
         s_sample = DW'(smp[i]);
         s_index  = IW'(idx0 + i);
         if (i == n - 1) begin
            e.acc_at = cyc + 1;
            exp_q.push_back(e);
         end
         @(posedge clk); #1;
      end
      // junk offered while busy must be ignored (R7)
      s_valid  = 1'b1;
      s_first  = 1'b1;
      s_last   = 1'b1;
      s_sample = '1;
      s_index  = '1;
      chk(!s_ready, use_last ? "R7" : "R10",
          {name, " ready low after closing sample"}, s_ready, 0);
      while (!s_ready) begin @(posedge clk); #1; end
      s_valid = 1'b0;
      s_first = 1'b0;
      s_last  = 1'b0;
   endtask

   task automatic send_partial(input int smp[$], input int idx0);
      @(posedge clk); #1;
      for (int i = 0; i < smp.size(); i++) begin
         s_valid  = 1'b1;
         s_first  = (i == 0);
         s_last   = 1'b0;
         s_sample = DW'(smp[i]);
         s_index  = IW'(idx0 + i);
         @(posedge clk); #1;
      end
      s_valid = 1'b0;
      s_first = 1'b0;
   endtask

   // monitor: pops the scoreboard when a result appears
   logic prev_valid = 1'b0;
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (prev_valid) chk(!t_valid, "R6", "result pulse width", t_valid, 0);
         if (t_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected result", 1, 0);
            else begin
               e = exp_q.pop_front();
               chk(t_miss == e.miss, "R5", {e.name, " miss flag"}, t_miss, e.miss);
               chk(t_time == e.t, "R4", {e.name, " time word"}, t_time, e.t);
               chk(cyc - e.acc_at == e.lat, "R8", {e.name, " latency"},
                   cyc - e.acc_at, e.lat);
               chk(s_ready, "R7", {e.name, " ready in result cycle"}, s_ready, 1);
            end
         end
      end
      prev_valid = rst_n && t_valid;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int v[$];
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(s_ready, "R7", "reset ready", s_ready, 1);
      chk(!t_valid, "R6", "reset valid", t_valid, 0);

      send_event('{100,100,120,300,700,1000,900,600,300,150}, 200, 128, 100, 1'b1,
                 "R2 R3 R4 half fraction");
      send_event('{100,100,140,500,1300,1900,1700,1100,500,200}, 300, 128, 100, 1'b1,
                 "R2 larger pulse");
      send_event('{100,100,120,300,700,1000,900,600,300,150}, 400, 51, 100, 1'b1,
                 "R2 low fraction");
      send_event('{100,100,120,300,700,1000,900,600,300,150}, 450, 250, 0, 1'b1,
                 "R4 high fraction");
      send_event('{900,600,300,100}, 10, 128, 100, 1'b1, "R5 peak first");
      send_event('{50,40,60,55}, 20, 128, 100, 1'b1, "R5 below baseline");
      send_event('{800,900,1000,700}, 30, 128, 0, 1'b1, "R5 no low sample");
      send_event('{0,500,800,200,0,300,800,100}, 40, 128, 0, 1'b1, "R1 equal peaks");
      send_event('{0,200,400,600,800}, 60, 128, 0, 1'b1, "R3 sample on threshold");
      send_partial('{3000,4000,3000}, 900);
      send_event('{100,100,120,300,700,1000,900,600,300,150}, 500, 128, 100, 1'b1,
                 "R9 restart");
      for (int i = 0; i < DEPTH + 4; i++) begin
         if (i < 18)      v.push_back(100);
         else if (i < 25) v.push_back(100 + (i - 17) * 250);
         else             v.push_back(1850 - (i - 24) * 150);
      end
      send_event(v, 1000, 128, 100, 1'b0, "R10 depth cap");

      while (exp_q.size() != 0) @(posedge clk);
      repeat (4) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule